// File: doc/BRIEF.md
# Saturating-Counter Branch History Table

This block is a direct-mapped table of small saturating counters that predicts the direction of conditional branches. A fetch stage presents a branch address on the lookup port and receives a taken or not-taken guess within the same cycle. The guess comes from the counter selected by a slice of low-order address bits. No tag is stored, so two branches whose addresses share that slice use the same counter.

When a branch resolves, the execute stage presents its address and real outcome on the update port. The selected counter moves one step toward the outcome and saturates at both ends. The counter width is a parameter. At one bit, each entry holds the last outcome and inverts whenever it mispredicts. At two or more bits, a guess must be wrong more than once before the predicted direction changes. The default build has 4096 entries of two bits each.

Top module: `bht_predictor`

## Requirements
- R1: The entry is selected by address bits `[IDX_LSB +: log2(DEPTH)]` only. Addresses that differ only in bits outside that slice (for example by a multiple of `DEPTH*4`, or in bits [1:0]) share one counter.
- R2: `lk_ctr` and `lk_taken` reflect the entry selected by `lk_pc` combinationally, in the same cycle that `lk_pc` is applied.
- R3: `lk_taken` is 1 exactly when the counter value is at least `2^(CTR_W-1)`, which is half of the counter range. Otherwise it is 0.
- R4: An update with `up_taken`=1 increments the selected counter. A counter already at `2^CTR_W-1` stays there.
- R5: An update with `up_taken`=0 decrements the selected counter. A counter already at 0 stays there.
- R6: While `rst_n` is low, and after it rises, every counter holds `2^(CTR_W-1)-1`. This is the weakly not-taken value: 1 for two-bit counters and 0 for one-bit counters.
- R7: An update is written at the clock edge and becomes visible to lookups from the next cycle. A lookup at the same index in the same cycle returns the value from before the update.
- R8: A cycle with `up_valid`=0 leaves every counter unchanged.
- R9: With `CTR_W`=1, the entry always equals the most recent outcome. It inverts on each mispredicted update.
- R10: With `CTR_W`=2, starting from the strongest state, two consecutive mispredictions are needed to change the predicted direction. A repeating loop of nine taken outcomes then one not-taken outcome gives one misprediction per iteration in steady state. A one-bit table gives two per iteration on the same loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | ADDR_W | Branch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_ctr | output | CTR_W | Counter value behind the prediction |
| up_valid | input | 1 | Resolved branch present this cycle |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A lookup result is due in the same cycle as its address. The bench therefore applies `lk_pc` just after the falling edge and samples `lk_taken` and `lk_ctr` 1 ns later, before the next rising edge. An update takes effect at the next rising edge. The reference model applies it only after that edge, so any lookup in the update's own cycle is compared against the old value. Loop-pattern miss counts are taken from the same-cycle predictions of the default two-bit table and of a second instance with one-bit counters.

// File: rtl/bht_pkg.sv
package bht_pkg;

    // Direction of a resolved or predicted branch.
    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } br_dir_e;

    // Counter width at or below which the table keeps last-outcome bits.
    localparam int unsigned LAST_OUTCOME_W = 1;

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned IDX_LSB = 2,
    parameter int unsigned IDX_W   = 12
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx
);
    // Only a slice of the address selects the entry; the rest is dropped.
    assign idx = pc[IDX_LSB +: IDX_W];

    logic unused_pc_bits;
    assign unused_pc_bits = ^pc;

endmodule

// File: rtl/bht_dir.sv
module bht_dir #(
    parameter int unsigned CTR_W = 2
) (
    input  logic [CTR_W-1:0] ctr,
    output logic             taken
);
    localparam logic [CTR_W-1:0] HALF = CTR_W'(1 << (CTR_W - 1));

    always_comb begin
        taken = (ctr >= HALF);
    end

endmodule

// File: rtl/bht_ctr_next.sv
module bht_ctr_next
    import bht_pkg::*;
#(
    parameter int unsigned CTR_W = 2
) (
    input  logic [CTR_W-1:0] cur,
    input  logic             outcome,
    output logic [CTR_W-1:0] nxt
);
    br_dir_e dir;
    assign dir = br_dir_e'(outcome);

    generate
        if (CTR_W <= LAST_OUTCOME_W) begin : g_flip
            // Single bit: invert only when the stored guess was wrong.
            always_comb begin
                nxt = cur;
                if (cur[0] != outcome) begin
                    nxt = ~cur;
                end
            end
        end else begin : g_sat
            localparam logic [CTR_W-1:0] TOP = {CTR_W{1'b1}};
            always_comb begin
                nxt = cur;
                unique case (dir)
                    DIR_TAKEN:     if (cur != TOP)        nxt = cur + 1'b1;
                    DIR_NOT_TAKEN: if (cur != '0)         nxt = cur - 1'b1;
                    default:                              nxt = cur;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/bht_table.sv
module bht_table #(
    parameter int unsigned CTR_W = 2,
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic [IDX_W-1:0] up_idx,
    output logic [CTR_W-1:0] up_ctr,
    input  logic             wr_en,
    input  logic [CTR_W-1:0] wr_ctr
);
    localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);

    typedef struct packed {
        logic [DEPTH-1:0][CTR_W-1:0] ctr;
    } tab_s;

    tab_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctr[up_idx] = wr_ctr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctr <= {DEPTH{WEAK_NT}};
        end else begin
            st_q <= st_d;
        end
    end

    // Both read ports see the registered state: same-cycle writes are not forwarded.
    assign rd_ctr = st_q.ctr[rd_idx];
    assign up_ctr = st_q.ctr[up_idx];

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned IDX_LSB = 2,
    parameter int unsigned CTR_W   = 2,
    parameter int unsigned DEPTH   = 4096,
    localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_taken,
    output logic [CTR_W-1:0]  lk_ctr,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken
);
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    logic [CTR_W-1:0] up_old_ctr;
    logic [CTR_W-1:0] up_new_ctr;

    bht_index #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_lk_index (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    bht_index #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_up_index (
        .pc  (up_pc),
        .idx (up_idx)
    );

    bht_table #(.CTR_W(CTR_W), .DEPTH(DEPTH)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_idx),
        .rd_ctr (lk_ctr),
        .up_idx (up_idx),
        .up_ctr (up_old_ctr),
        .wr_en  (up_valid),
        .wr_ctr (up_new_ctr)
    );

    bht_ctr_next #(.CTR_W(CTR_W)) u_next (
        .cur     (up_old_ctr),
        .outcome (up_taken),
        .nxt     (up_new_ctr)
    );

    bht_dir #(.CTR_W(CTR_W)) u_dir (
        .ctr   (lk_ctr),
        .taken (lk_taken)
    );

endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
    parameter int unsigned CTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_valid,
    input logic             up_taken,
    input logic [CTR_W-1:0] up_old,
    input logic [CTR_W-1:0] up_new,
    input logic [CTR_W-1:0] lk_ctr,
    input logic             lk_taken
);
    localparam logic [CTR_W-1:0] TOP  = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] HALF = CTR_W'(1 << (CTR_W - 1));

    // R3
    threshold_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken == (lk_ctr >= HALF));

    // R4
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && up_old == TOP) |-> up_new == TOP);

    // R5
    sat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && up_old == '0) |-> up_new == '0);

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && up_old != TOP) |-> up_new == up_old + 1'b1);

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && up_old != '0) |-> up_new == up_old - 1'b1);

    generate
        if (CTR_W == 1) begin : g_one
            // R9
            last_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |-> up_new[0] == up_taken);
        end
    endgenerate

endmodule

bind bht_predictor bht_checker #(.CTR_W(CTR_W)) u_bht_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .up_old   (up_old_ctr),
    .up_new   (up_new_ctr),
    .lk_ctr   (lk_ctr),
    .lk_taken (lk_taken)
);

// File: tb/bht_predictor_tb.sv
module bht_predictor_tb_top;
    localparam int D2 = 4096;
    localparam int D1 = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [31:0] up_pc = '0;
    logic        up_valid = 1'b0;
    logic        up_taken = 1'b0;
    logic        lk_taken2, lk_taken1;
    logic [1:0]  lk_ctr2;
    logic [0:0]  lk_ctr1;

    always #4 clk = ~clk;

    bht_predictor dut_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken2),
        .lk_ctr(lk_ctr2), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    bht_predictor #(.CTR_W(1), .DEPTH(D1)) dut1_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken1),
        .lk_ctr(lk_ctr1), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    int m2 [D2];
    int m1 [D1];
    int checks = 0;
    int failures = 0;
    int miss2 = 0;
    int miss1 = 0;
    logic done = 1'b0;

    function automatic int ix2(logic [31:0] pc);
        return int'((pc >> 2) % D2);
    endfunction

    function automatic int ix1(logic [31:0] pc);
        return int'((pc >> 2) % D1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < D2; i++) m2[i] = 1;
        for (int i = 0; i < D1; i++) m1[i] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        up_valid = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle: drive, compare the same-cycle lookup, then apply the edge to the model.
    task automatic step(input logic [31:0] lpc, input logic uv, input logic [31:0] upc,
                        input logic ut, input string req);
        int e2, e1;
        @(negedge clk);
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
        #1;
        e2 = m2[ix2(lpc)];
        e1 = m1[ix1(lpc)];
        check(lk_ctr2 == 2'(e2), req, int'(lk_ctr2), e2);
        check(lk_taken2 == (e2 >= 2), {req, "/R3"}, int'(lk_taken2), int'(e2 >= 2));
        check(lk_taken1 == (e1 >= 1), {req, "/R9"}, int'(lk_taken1), e1);
        if (uv && lpc == upc) begin
            if (lk_taken2 != ut) miss2++;
            if (lk_taken1 != ut) miss1++;
        end
        @(posedge clk);
        if (uv) begin
            if (ut) begin
                if (m2[ix2(upc)] < 3) m2[ix2(upc)]++;
            end else begin
                if (m2[ix2(upc)] > 0) m2[ix2(upc)]--;
            end
            m1[ix1(upc)] = ut ? 1 : 0;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [31:0] lf;
        model_reset();
        do_reset();

        // R6: weakly not-taken everywhere after reset
        step(32'h0000_0000, 1'b0, '0, 1'b0, "R6");
        step(32'h0000_0100, 1'b0, '0, 1'b0, "R6");
        step(32'h0000_FFFC, 1'b0, '0, 1'b0, "R6");
        check(lk_ctr2 == 2'd1, "R6", int'(lk_ctr2), 1);

        // R8: idle update lines carry data but do nothing
        a = 32'h0000_0040;
        step(a, 1'b0, a, 1'b1, "R8");
        step(a, 1'b0, a, 1'b1, "R8");
        check(lk_ctr2 == 2'd1, "R8", int'(lk_ctr2), 1);

        // R4: climb and saturate at 3
        for (int i = 0; i < 5; i++) step(a, 1'b1, a, 1'b1, "R4");
        step(a, 1'b0, '0, 1'b0, "R4");
        check(lk_ctr2 == 2'd3, "R4", int'(lk_ctr2), 3);

        // R10: from strongest, first miss keeps direction, second flips it
        step(a, 1'b1, a, 1'b0, "R10");
        step(a, 1'b0, '0, 1'b0, "R10");
        check(lk_taken2 == 1'b1, "R10", int'(lk_taken2), 1);
        step(a, 1'b1, a, 1'b0, "R10");
        step(a, 1'b0, '0, 1'b0, "R10");
        check(lk_taken2 == 1'b0, "R10", int'(lk_taken2), 0);

        // R5: fall and saturate at 0
        for (int i = 0; i < 4; i++) step(a, 1'b1, a, 1'b0, "R5");
        step(a, 1'b0, '0, 1'b0, "R5");
        check(lk_ctr2 == 2'd0, "R5", int'(lk_ctr2), 0);

        // R1: aliases above the index and in the low bits share the entry
        step(a, 1'b1, a + 32'(D2 * 4), 1'b1, "R1");
        step(a | 32'h3, 1'b1, a + 32'(D2 * 8), 1'b1, "R1");
        step(a, 1'b0, '0, 1'b0, "R1");
        check(lk_ctr2 == 2'd2, "R1", int'(lk_ctr2), 2);

        // R7: same-cycle lookup sees the old value, next cycle the new one
        step(a, 1'b1, a, 1'b0, "R7");
        check(lk_ctr2 == 2'd2, "R7", int'(lk_ctr2), 2);
        step(a, 1'b0, '0, 1'b0, "R7");
        check(lk_ctr2 == 2'd1, "R7", int'(lk_ctr2), 1);

        // R9/R10: loop of nine taken then one not taken
        a = 32'h0000_0200;
        for (int it = 0; it < 6; it++) begin
            if (it == 1) begin miss2 = 0; miss1 = 0; end
            for (int k = 0; k < 10; k++) step(a, 1'b1, a, (k != 9), "R10");
        end
        check(miss2 == 5, "R10 two-bit misses", miss2, 5);
        check(miss1 == 10, "R9 one-bit misses", miss1, 10);

        // R2: pseudo-random mixed traffic against the model
        lf = 32'hACE1_1234;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step({20'h0, 6'h0, lf[5:0]} << 2, lf[7], {20'h0, 6'h0, lf[13:8]} << 2, lf[9], "R2");
        end

        // R6: reset mid-run restores the weak state
        do_reset();
        step(a, 1'b0, '0, 1'b0, "R6");
        check(lk_ctr2 == 2'd1 && lk_ctr1 == 1'b0, "R6", int'(lk_ctr2), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule